// File: doc/BRIEF.md
# Synchronous DRAM Power-Up Initializer

This block brings synchronous DRAM-class memories out of power-up for a memory controller. While the controller runs its power-up refresh cycles, the block counts those cycles. On each one it samples a memory-type strap. The strap is active low: a 0 means synchronous memory is fitted.

When the last counted refresh cycle has passed and synchronous memory was seen, the block issues two commands in order. The first closes every bank. The second loads the mode register. The 12-bit mode word is built from two configuration straps, which are captured in the cycle the mode-register command starts. The word is placed on a 16-bit logical address bus, shifted left by the bus-size code. If no synchronous memory was seen, no command is issued.

In both cases a done flag then rises and stays high. That flag opens the gate for normal memory requests. Commands leave on a one-cycle valid strobe together with a 2-bit type field.

Top module: `sdram_pwrup_init`

## Requirements
- R1: While reset is asserted and just after it, `cmd_valid` is 0, `cmd_type` is 0, `addr_out` is 0, `init_done` is 0 and `mem_grant` is 0.
- R2: No command is issued before the REF_CNT-th pulse on `refresh_tick` (default 4) has been sampled.
- R3: `mem_type_n` is sampled on every counted refresh pulse. If it reads 0 on any of them, the command sequence runs. Otherwise no command is ever issued, and `init_done` rises in the cycle after the final pulse.
- R4: The sequence is a deactivate-all-banks command (`cmd_type` = 1) in the cycle after the final pulse, followed by a mode-register command (`cmd_type` = 2). Each command has `cmd_valid` high for exactly one cycle.
- R5: The mode-register strobe comes exactly CMD_GAP clocks after the deactivate strobe (default 3, minimum 2).
- R6: Mode word bits 11:6 are 0 and bit 5 is 1. Bit 4 equals `cfg_a` and bits 3:1 are 0. Bit 0 equals `cfg_b`.
- R7: `cfg_a`, `cfg_b` and `bus_code` are captured at the clock edge where the mode-register cycle starts. Changes to them before that edge are reflected in the word.
- R8: `addr_out` carries the mode word shifted left by `bus_code`: 0 puts it in bits 11:0, 1 in bits 12:1, 2 in bits 13:2 and 3 in bits 14:3. All other bits are 0.
- R9: `addr_out` is 0 in every cycle except the one where a mode-register command is valid, and that includes the deactivate cycle.
- R10: `init_done` rises in the cycle after the mode-register strobe and stays high until reset. `mem_grant` equals `mem_req` while `init_done` is high and is 0 before that.
- R11: While `cmd_valid` is 0, `cmd_type` reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| refresh_tick | input | 1 | One-cycle pulse per power-up refresh cycle |
| mem_type_n | input | 1 | Memory-type strap, 0 = synchronous memory present |
| cfg_a | input | 1 | Configuration strap driving mode bit 4 |
| cfg_b | input | 1 | Configuration strap driving mode bit 0 |
| bus_code | input | 2 | Bus-size code, left shift of the mode word |
| mem_req | input | 1 | Normal memory cycle request |
| cmd_valid | output | 1 | One-cycle command strobe |
| cmd_type | output | 2 | 0 idle, 1 deactivate all banks, 2 mode register set |
| addr_out | output | 16 | Logical address, mode word during the mode-register command |
| init_done | output | 1 | Initialization complete, sticky until reset |
| mem_grant | output | 1 | Request passed through once initialization is complete |

## Verification
Several properties are checked on every cycle: the address stays zero outside a valid mode-register command, the type field stays zero when idle, each strobe is a single cycle, and the mode word has the right population. They also check that done follows the mode-register strobe and then stays high, and that no grant appears before done. Other behaviours only the bench scenarios can show. These are the refresh-count threshold, the decision from the memory-type strap, and the exact deactivate-to-mode gap. They also include the value and alignment of the word for every bus-size code, and the capture of straps changed late in the sequence.

// File: rtl/sdram_pwrup_init.sv
module sdram_pwrup_init #(
  parameter int REF_CNT = 4,
  parameter int CMD_GAP = 3,
  parameter int AW      = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          refresh_tick,
  input  logic          mem_type_n,
  input  logic          cfg_a,
  input  logic          cfg_b,
  input  logic [1:0]    bus_code,
  input  logic          mem_req,
  output logic          cmd_valid,
  output logic [1:0]    cmd_type,
  output logic [AW-1:0] addr_out,
  output logic          init_done,
  output logic          mem_grant
);
  localparam int RW = $clog2(REF_CNT + 1);
  localparam int GW = $clog2(CMD_GAP + 1);

  typedef enum logic [2:0] {S_REF, S_DEACT, S_GAP, S_MRS, S_DONE} st_t;

  st_t           state;
  logic [RW-1:0] ref_n;
  logic [GW-1:0] gap_n;
  logic          sync_q, a_q, b_q;
  logic [1:0]    bus_q;

  wire sync_now = sync_q | ~mem_type_n;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state  <= S_REF;
      ref_n  <= '0;
      gap_n  <= '0;
      sync_q <= 1'b0;
      a_q    <= 1'b0;
      b_q    <= 1'b0;
      bus_q  <= 2'd0;
    end else begin
      case (state)
        S_REF: if (refresh_tick) begin
          sync_q <= sync_now;
          if (ref_n == RW'(REF_CNT - 1))
            state <= sync_now ? S_DEACT : S_DONE;
          else
            ref_n <= ref_n + 1'b1;
        end
        S_DEACT: begin
          gap_n <= '0;
          state <= S_GAP;
        end
        S_GAP: begin
          if (gap_n == GW'(CMD_GAP - 2)) begin
            a_q   <= cfg_a;
            b_q   <= cfg_b;
            bus_q <= bus_code;
            state <= S_MRS;
          end else begin
            gap_n <= gap_n + 1'b1;
          end
        end
        S_MRS:   state <= S_DONE;
        default: state <= S_DONE;
      endcase
    end
  end

  wire [11:0]   mode_word = {6'b0, 1'b1, a_q, 3'b0, b_q};
  wire [AW-1:0] mode_ext  = AW'(mode_word);

  assign cmd_valid = (state == S_DEACT) || (state == S_MRS);
  assign cmd_type  = (state == S_DEACT) ? 2'd1 : (state == S_MRS) ? 2'd2 : 2'd0;
  assign addr_out  = (state == S_MRS) ? (mode_ext << bus_q) : '0;
  assign init_done = (state == S_DONE);
  assign mem_grant = mem_req & init_done;

  // R9
  addr_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(cmd_valid && cmd_type == 2'd2) |-> addr_out == '0);
  // R11
  idle_type_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_valid |-> cmd_type == 2'd0);
  // R4
  single_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |=> !cmd_valid);
  // R6
  mode_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_type == 2'd2) |-> ($countones(addr_out) >= 1 && $countones(addr_out) <= 3));
  // R10
  done_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_type == 2'd2) |=> init_done);
  // R10
  done_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    init_done |=> init_done);
  // R10
  grant_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_grant |-> init_done);
endmodule

// File: tb/sim_sdram_pwrup_init.sv
module sim_sdram_pwrup_init;
  localparam int REF_CNT = 4;
  localparam int CMD_GAP = 3;

  logic clk = 0, rst_n = 0, refresh_tick = 0, mem_type_n = 1, cfg_a = 0, cfg_b = 0, mem_req = 0;
  logic [1:0] bus_code = 0;
  logic cmd_valid, init_done, mem_grant;
  logic [1:0] cmd_type;
  logic [15:0] addr_out;

  sdram_pwrup_init #(.REF_CNT(REF_CNT), .CMD_GAP(CMD_GAP), .AW(16)) u0 (
    .clk(clk), .rst_n(rst_n), .refresh_tick(refresh_tick), .mem_type_n(mem_type_n),
    .cfg_a(cfg_a), .cfg_b(cfg_b), .bus_code(bus_code), .mem_req(mem_req),
    .cmd_valid(cmd_valid), .cmd_type(cmd_type), .addr_out(addr_out),
    .init_done(init_done), .mem_grant(mem_grant));

  always #4 clk = ~clk;

  typedef struct packed { logic [1:0] typ; logic [15:0] addr; } item_t;
  item_t exp_q[$];
  int compared = 0, mismatched = 0, cyc = 0, last_deact = -1;
  logic armed = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] mode_of(input logic a, input logic b, input logic [1:0] bc);
    logic [15:0] w;
    w = 16'h0020 | (16'(a) << 4) | 16'(b);
    return w << bc;
  endfunction

  // monitor: pops expected items as commands appear
  initial forever begin
    @(posedge clk); #2;
    cyc++;
    if (rst_n && cmd_valid) begin
      if (!armed) chk(0, "R2 command before last refresh", cmd_type, 0);
      else if (exp_q.size() == 0) chk(0, "R3/R4 unexpected command", cmd_type, 0);
      else begin
        item_t e;
        e = exp_q.pop_front();
        chk(cmd_type == e.typ, "R4 command type", cmd_type, e.typ);
        chk(addr_out == e.addr, "R6/R8/R9 address", addr_out, e.addr);
        if (cmd_type == 2'd1) last_deact = cyc;
        if (cmd_type == 2'd2) chk(cyc - last_deact == CMD_GAP, "R5 gap", cyc - last_deact, CMD_GAP);
      end
    end
  end

  task automatic run(input logic sync_pulse2, input logic a0, input logic b0,
                     input logic a1, input logic b1, input logic [1:0] bc);
    @(negedge clk);
    rst_n = 0; armed = 0; refresh_tick = 0; mem_req = 1; mem_type_n = 1;
    cfg_a = a0; cfg_b = b0; bus_code = bc;
    exp_q.delete();
    repeat (2) @(negedge clk);
    chk(!cmd_valid && cmd_type == 0 && addr_out == 0 && !init_done && !mem_grant,
        "R1 reset state", {cmd_valid, cmd_type, init_done, mem_grant}, 0);
    rst_n = 1;
    if (sync_pulse2) begin
      exp_q.push_back('{2'd1, 16'h0});
      exp_q.push_back('{2'd2, mode_of(a1, b1, bc)});
    end
    for (int i = 0; i < REF_CNT; i++) begin
      repeat (2) @(negedge clk);
      mem_type_n = (sync_pulse2 && i == 1) ? 1'b0 : 1'b1;
      if (i == REF_CNT - 1) armed = 1;
      refresh_tick = 1;
      @(negedge clk);
      refresh_tick = 0;
      mem_type_n = sync_pulse2 ? 1'b1 : 1'b0; // strap low only between pulses when no sync
      if (i < REF_CNT - 1) chk(!init_done && !mem_grant, "R10 grant blocked", mem_grant, 0);
      if (i == REF_CNT - 1 && !sync_pulse2)
        chk(init_done, "R3 done without commands", init_done, 1);
    end
    cfg_a = a1; cfg_b = b1;   // late strap change before mode cycle (R7)
    repeat (CMD_GAP + 6) @(negedge clk);
    chk(exp_q.size() == 0, "R4 all commands seen", exp_q.size(), 0);
    chk(init_done && mem_grant, "R10 done and grant", {init_done, mem_grant}, 3);
    mem_req = 0;
    @(negedge clk);
    chk(!mem_grant && init_done, "R10 grant follows request", mem_grant, 0);
  endtask

  task automatic summary;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  endtask

  initial begin
    run(1, 0, 0, 1, 1, 2'd0);
    run(1, 1, 0, 0, 1, 2'd1);
    run(1, 0, 1, 1, 0, 2'd2);
    run(1, 0, 0, 1, 1, 2'd3);
    run(0, 1, 1, 1, 1, 2'd3);
    summary();
  end

  initial begin
    repeat (100000) @(posedge clk);
    compared++; mismatched++;
    $display("FAIL watchdog actual=0x0 expected=0x1");
    summary();
  end
endmodule